// File: doc/BRIEF.md
# Serial EEPROM Random-Access Sequencer

This block sits between a host and a byte-level two-wire bus master. It carries out one of two transactions on a serial EEPROM with a 16-bit memory address: a single-byte write, or a single-byte random read. The host gives a 7-bit device select, a memory address, a write byte and a read/write flag. The sequencer latches these values and raises busy. It then answers each status event from the bus master with one command. A command carries the byte to shift out, START and STOP requests, and the acknowledge level to drive on the next received byte.

Both kinds of transaction first send the device address with the write bit and then the two memory address bytes, high byte first. A write sends the data byte next and finishes with STOP. A read asks for a repeated START, sends the device address again with the read bit, receives one byte with a NACK, and finishes with STOP. When the EEPROM does not acknowledge, the sequencer orders STOP plus START and runs the whole transaction again. A bus-error status ends the transaction and sets an error flag.

Top module: `eeseq_top`

## Requirements
- R1: When `req_i` is sampled high while `busy_o` is low, `busy_o` is high on the next cycle and a command with `cmd_start_o`=1 and `cmd_stop_o`=0 is issued in that same cycle.
- R2: Status code 1 (START sent) produces a command whose byte is {device select, 0} for both reads and writes.
- R3: Status code 3 (device write-address acknowledged) loads the high memory-address byte. The next status code 5 (byte acknowledged) loads the low byte.
- R4: In a write, code 5 after the low byte loads the data byte. Code 5 after the data byte produces a STOP-only command, pulses `done_o` and clears `busy_o` in the same cycle.
- R5: In a read, code 5 after the low byte produces a START-only command (repeated START). Code 2 (repeated START sent) then loads {device select, 1}.
- R6: In a read, code 7 (read address acknowledged) produces a command with `cmd_ack_o`=0. Code 10 or 9 (byte received) stores `rx_byte_i` in `rd_data_o`, issues STOP, pulses `done_o` and clears busy.
- R7: Code 4 (address NACK), code 6 (byte NACK) or code 8 (read address NACK) produces a command with both START and STOP set. Busy stays high, and the next code 1 restarts the transaction from the device address.
- R8: A request made while busy produces no command and leaves the latched transaction unchanged.
- R9: A status event while not busy produces no command and leaves `busy_o` low.
- R10: Code 0 (bus error) produces a STOP-only command, clears busy, pulses `done_o` and sets `err_o`. `err_o` is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request strobe |
| rnw_i | input | 1 | 1 = read, 0 = write |
| dev_i | input | 7 | Device select |
| mem_addr_i | input | 16 | EEPROM memory address |
| wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when a transaction ends |
| err_o | output | 1 | Last transaction ended on a bus error |
| rd_data_o | output | 8 | Byte returned by the last read |
| stat_valid_i | input | 1 | Status event strobe from the bus master |
| stat_i | input | 4 | Status code |
| rx_byte_i | input | 8 | Byte received by the bus master |
| cmd_valid_o | output | 1 | Command strobe to the bus master |
| cmd_start_o | output | 1 | Request START / repeated START |
| cmd_stop_o | output | 1 | Request STOP |
| cmd_ack_o | output | 1 | Acknowledge level for the next received byte |
| tx_byte_o | output | 8 | Byte to transmit |

## Verification
The bench targets the read's first address phase. A design that copied the read flag into the first address byte would send the device address with the read bit too early. It also drives a NACK in the middle of an address sequence. A design that did not reset its byte counter on a retry would send the low byte where the high byte belongs. It makes a request while a transaction is running; a design that latched it would corrupt the address bytes that follow. It checks the error flag across a bus-error abort and a following request, and a design that did not clear the flag would show a stale error.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    EV_BUS_ERR   = 4'd0,
    EV_START     = 4'd1,
    EV_RSTART    = 4'd2,
    EV_WADR_ACK  = 4'd3,
    EV_WADR_NACK = 4'd4,
    EV_WDAT_ACK  = 4'd5,
    EV_WDAT_NACK = 4'd6,
    EV_RADR_ACK  = 4'd7,
    EV_RADR_NACK = 4'd8,
    EV_RDAT_ACK  = 4'd9,
    EV_RDAT_NACK = 4'd10
  } ev_e;

  // last byte placed on the bus in the address/data phase
  typedef enum logic [1:0] {PH_HI, PH_LO, PH_DATA} phase_e;

  typedef struct packed {
    logic              start;
    logic              stop;
    logic              ack;
    logic              load;
    logic [BYTE_W-1:0] tx;
    logic              finish;
    logic              err;
    logic              capture;
  } act_t;
endpackage

// File: rtl/eeseq_req.sv
module eeseq_req
  import eeseq_pkg::*;
#(
  parameter int unsigned DEV_W  = BYTE_W - 1,
  parameter int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              accept_i,
  input  logic              finish_i,
  input  logic              rnw_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rnw_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      rnw_o   <= 1'b0;
      dev_o   <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      busy_o  <= 1'b1;
      rnw_o   <= rnw_i;
      dev_o   <= dev_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end else if (finish_i) begin
      busy_o  <= 1'b0;
    end
  end

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i)); // R1
  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(dev_o) && $stable(wdata_o))); // R8
endmodule

// File: rtl/eeseq_step.sv
module eeseq_step
  import eeseq_pkg::*;
#(
  parameter int unsigned DEV_W  = BYTE_W - 1,
  parameter int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  ev_e               ev_i,
  input  logic              rnw_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output act_t              act_o
);
  phase_e ph_q, ph_d;
  logic   ph_we;

  always_comb begin
    act_o     = '0;
    act_o.ack = 1'b1;
    ph_d      = ph_q;
    ph_we     = 1'b0;
    unique case (ev_i)
      EV_START: begin
        act_o.load = 1'b1;
        act_o.tx   = {dev_i, 1'b0};  // memory address always written first
      end
      EV_RSTART: begin
        act_o.load = 1'b1;
        act_o.tx   = {dev_i, 1'b1};
      end
      EV_WADR_ACK: begin
        act_o.load = 1'b1;
        act_o.tx   = addr_i[ADDR_W-1 -: BYTE_W];
        ph_d       = PH_HI;
        ph_we      = 1'b1;
      end
      EV_WDAT_ACK: begin
        unique case (ph_q)
          PH_HI: begin
            act_o.load = 1'b1;
            act_o.tx   = addr_i[BYTE_W-1:0];
            ph_d       = PH_LO;
            ph_we      = 1'b1;
          end
          PH_LO: begin
            if (rnw_i) begin
              act_o.start = 1'b1;
            end else begin
              act_o.load = 1'b1;
              act_o.tx   = wdata_i;
              ph_d       = PH_DATA;
              ph_we      = 1'b1;
            end
          end
          default: begin
            act_o.stop   = 1'b1;
            act_o.finish = 1'b1;
          end
        endcase
      end
      EV_WADR_NACK, EV_WDAT_NACK, EV_RADR_NACK: begin
        act_o.stop  = 1'b1;
        act_o.start = 1'b1;
      end
      EV_RADR_ACK: act_o.ack = 1'b0;  // single byte: NACK it
      EV_RDAT_ACK, EV_RDAT_NACK: begin
        act_o.capture = 1'b1;
        act_o.stop    = 1'b1;
        act_o.finish  = 1'b1;
      end
      default: begin
        act_o.stop   = 1'b1;
        act_o.finish = 1'b1;
        act_o.err    = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= PH_HI;
    else if (fire_i && ph_we)  ph_q <= ph_d;
  end
endmodule

// File: rtl/eeseq_cmd.sv
module eeseq_cmd
  import eeseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              fire_i,
  input  act_t              act_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              cmd_valid_o,
  output logic              cmd_start_o,
  output logic              cmd_stop_o,
  output logic              cmd_ack_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_start_o <= 1'b0;
      cmd_stop_o  <= 1'b0;
      cmd_ack_o   <= 1'b1;
      tx_byte_o   <= '0;
      rd_data_o   <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      cmd_start_o <= 1'b0;
      cmd_stop_o  <= 1'b0;
      done_o      <= 1'b0;
      if (accept_i) begin
        cmd_valid_o <= 1'b1;
        cmd_start_o <= 1'b1;
        cmd_ack_o   <= 1'b1;
        err_o       <= 1'b0;
      end else if (fire_i) begin
        cmd_valid_o <= 1'b1;
        cmd_start_o <= act_i.start;
        cmd_stop_o  <= act_i.stop;
        cmd_ack_o   <= act_i.ack;
        done_o      <= act_i.finish;
        if (act_i.load)    tx_byte_o <= act_i.tx;
        if (act_i.capture) rd_data_o <= rx_byte_i;
        if (act_i.err)     err_o     <= 1'b1;
      end
    end
  end

  AST_ERR_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (cmd_stop_o && done_o && !cmd_start_o)); // R10
endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter int unsigned DEV_W  = BYTE_W - 1,
  parameter int unsigned ADDR_W = 2 * BYTE_W,
  parameter int unsigned STAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rnw_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              stat_valid_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              cmd_valid_o,
  output logic              cmd_start_o,
  output logic              cmd_stop_o,
  output logic              cmd_ack_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  logic              accept, fire, rnw_q;
  logic [DEV_W-1:0]  dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  act_t              act;

  assign accept = req_i && !busy_o;
  assign fire   = stat_valid_i && busy_o;

  eeseq_req #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_req (
    .clk_i, .rst_ni, .req_i, .accept_i(accept), .finish_i(fire && act.finish),
    .rnw_i, .dev_i, .addr_i(mem_addr_i), .wdata_i,
    .busy_o, .rnw_o(rnw_q), .dev_o(dev_q), .addr_o(addr_q), .wdata_o(wdata_q)
  );

  eeseq_step #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_step (
    .clk_i, .rst_ni, .fire_i(fire), .ev_i(ev_e'(stat_i)),
    .rnw_i(rnw_q), .dev_i(dev_q), .addr_i(addr_q), .wdata_i(wdata_q), .act_o(act)
  );

  eeseq_cmd u_cmd (
    .clk_i, .rst_ni, .accept_i(accept), .fire_i(fire), .act_i(act), .rx_byte_i,
    .cmd_valid_o, .cmd_start_o, .cmd_stop_o, .cmd_ack_o, .tx_byte_o,
    .rd_data_o, .done_o, .err_o
  );

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ($past(busy_o) || $past(req_i))); // R9
  AST_FIRST_ADDR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && $past(stat_valid_i && busy_o && stat_i == STAT_W'(EV_START)))
      |-> !tx_byte_o[0]); // R2
  AST_DONE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cmd_stop_o)); // R4
endmodule

// File: tb/eeseq_top_test.sv
module eeseq_top_test;
  typedef struct {
    bit       s, p, a;
    bit [7:0] tx;
    bit       ctx, busy, done, err;
    string    tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, rnw_i = 1'b0, stat_valid_i = 1'b0;
  logic [6:0] dev_i = '0;
  logic [15:0] mem_addr_i = '0;
  logic [7:0] wdata_i = '0, rx_byte_i = '0;
  logic [3:0] stat_i = '0;
  logic busy_o, done_o, err_o, cmd_valid_o, cmd_start_o, cmd_stop_o, cmd_ack_o;
  logic [7:0] rd_data_o, tx_byte_o;

  int n_chk = 0, n_bad = 0;
  bit ended = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  eeseq_top uut (
    .clk_i(clk), .rst_ni, .req_i, .rnw_i, .dev_i, .mem_addr_i, .wdata_i,
    .busy_o, .done_o, .err_o, .rd_data_o, .stat_valid_i, .stat_i, .rx_byte_i,
    .cmd_valid_o, .cmd_start_o, .cmd_stop_o, .cmd_ack_o, .tx_byte_o
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(bit s, bit p, bit a, bit [7:0] tx, bit ctx,
                      bit busy, bit done, bit err, string tag);
    exp_t e;
    e.s = s; e.p = p; e.a = a; e.tx = tx; e.ctx = ctx;
    e.busy = busy; e.done = done; e.err = err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic request(bit rnw, bit [6:0] dev, bit [15:0] addr, bit [7:0] wd);
    @(negedge clk);
    req_i = 1'b1; rnw_i = rnw; dev_i = dev; mem_addr_i = addr; wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic ev(bit [3:0] code, bit [7:0] rx = 8'h00);
    @(negedge clk);
    stat_valid_i = 1'b1; stat_i = code; rx_byte_i = rx;
    @(negedge clk);
    stat_valid_i = 1'b0;
  endtask

  // monitor: compare each command against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && cmd_valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9/R8 unexpected command", {28'd0, cmd_start_o, cmd_stop_o, cmd_ack_o, 1'b1}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({cmd_start_o, cmd_stop_o, cmd_ack_o} == {e.s, e.p, e.a}, e.tag,
            {cmd_start_o, cmd_stop_o, cmd_ack_o}, {e.s, e.p, e.a});
        if (e.ctx) chk(tx_byte_o == e.tx, e.tag, tx_byte_o, e.tx);
        chk({busy_o, done_o, err_o} == {e.busy, e.done, e.err}, e.tag,
            {busy_o, done_o, err_o}, {e.busy, e.done, e.err});
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !err_o && !done_o, "reset R1",
        {busy_o, cmd_valid_o, err_o, done_o}, 0);

    // write: device 0x50, address 0x0242, data 0xF0
    push(1,0,1,8'h00,0,1,0,0,"R1 accept");  request(0, 7'h50, 16'h0242, 8'hF0);
    push(0,0,1,8'hA0,1,1,0,0,"R2 wr addr"); ev(1);
    push(0,0,1,8'h02,1,1,0,0,"R3 hi");      ev(3);
    push(0,0,1,8'h42,1,1,0,0,"R3 lo");      ev(5);
    push(0,0,1,8'hF0,1,1,0,0,"R4 data");    ev(5);
    push(0,1,1,8'h00,0,0,1,0,"R4 stop");    ev(5);

    // read: device 0x51, address 0x0088, address NACK retry, refused request
    push(1,0,1,8'h00,0,1,0,0,"R1 accept rd"); request(1, 7'h51, 16'h0088, 8'h00);
    push(0,0,1,8'hA2,1,1,0,0,"R2 rd forced W"); ev(1);
    push(1,1,1,8'h00,0,1,0,0,"R7 addr nack");   ev(4);
    push(0,0,1,8'hA2,1,1,0,0,"R7 restart");     ev(1);
    request(0, 7'h33, 16'hFFFF, 8'h11);
    push(0,0,1,8'h00,1,1,0,0,"R8 hi kept");     ev(3);
    push(0,0,1,8'h88,1,1,0,0,"R8 lo kept");     ev(5);
    push(1,0,1,8'h00,0,1,0,0,"R5 rstart req");  ev(5);
    push(0,0,1,8'hA3,1,1,0,0,"R5 rd addr");     ev(2);
    push(0,0,0,8'h00,0,1,0,0,"R6 nack byte");   ev(7);
    push(0,1,1,8'h00,0,0,1,0,"R6 stop");        ev(10, 8'h5A);
    chk(rd_data_o == 8'h5A, "R6 rd_data", rd_data_o, 8'h5A);

    // write with data NACK retry
    push(1,0,1,8'h00,0,1,0,0,"R1 accept 3"); request(0, 7'h52, 16'h1234, 8'h77);
    push(0,0,1,8'hA4,1,1,0,0,"R2 addr 3");   ev(1);
    push(0,0,1,8'h12,1,1,0,0,"R3 hi 3");     ev(3);
    push(0,0,1,8'h34,1,1,0,0,"R3 lo 3");     ev(5);
    push(0,0,1,8'h77,1,1,0,0,"R4 data 3");   ev(5);
    push(1,1,1,8'h00,0,1,0,0,"R7 data nack"); ev(6);
    push(0,0,1,8'hA4,1,1,0,0,"R7 re addr");  ev(1);
    push(0,0,1,8'h12,1,1,0,0,"R7 hi again"); ev(3);
    push(0,0,1,8'h34,1,1,0,0,"R7 lo again"); ev(5);
    push(0,0,1,8'h77,1,1,0,0,"R7 data again"); ev(5);
    push(0,1,1,8'h00,0,0,1,0,"R4 stop 3");   ev(5);

    // events while idle
    ev(1); ev(7); ev(10, 8'hC3);
    repeat (2) @(negedge clk);
    chk(!busy_o, "R9 idle busy", busy_o, 0);
    chk(rd_data_o == 8'h5A, "R9 rd_data kept", rd_data_o, 8'h5A);

    // bus error, then error flag cleared on next accept
    push(1,0,1,8'h00,0,1,0,0,"R1 accept 4"); request(0, 7'h53, 16'h0001, 8'h01);
    push(0,0,1,8'hA6,1,1,0,0,"R2 addr 4");   ev(1);
    push(0,1,1,8'h00,0,0,1,1,"R10 abort");   ev(0);
    @(negedge clk);
    chk(err_o && !busy_o, "R10 err held", {err_o, busy_o}, 2'b10);
    push(1,0,1,8'h00,0,1,0,0,"R10 err clear"); request(1, 7'h54, 16'h0002, 8'h00);
    push(0,0,1,8'hA8,1,1,0,0,"R2 addr 5");     ev(1);
    push(0,1,1,8'h00,0,0,1,1,"R10 abort 2");   ev(0);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "all commands seen", q.size(), 0);
    finish_run();
  end
endmodule